// File: doc/BRIEF.md
# Variant-Selectable 6502-Subset Executor

A small multi-cycle core that runs a handful of 6502-family instructions. It makes one bus cycle per clock. A static two-bit personality input picks one of four decode flavours: the original NMOS part, the plain CMOS part without bit instructions, the CMOS part with bit instructions, and the 16-bit-capable part running in emulation mode. Opcode $47 is the one instruction whose meaning depends on the personality. Its bus-cycle sequence follows each flavour cycle by cycle.

The core drives a 24-bit address, an 8-bit write-data bus and separate read and write strobes. It takes read data in the same cycle, from a combinational memory. The accumulator and the N/Z/C flags are visible as outputs. Any opcode that the chosen personality does not support stops the core and raises a sticky halt. A system can therefore run a short probe program and then read the accumulator to tell which personality it is running.

Top module: `vsx_core`

## Requirements
- R1: While reset is held, the core drives an opcode read at address RESET_PC (rd_o=1, wr_o=0). The accumulator, flags_o and halt_o are all zero.
- R2: Load-immediate ($A9) and compare-immediate ($C9) each take 2 bus cycles. Load sets N and Z from the value. Compare leaves A unchanged and sets N and Z from A minus the operand. It sets C when A is greater than or equal to the operand. flags_o is {N,Z,C}, with N in bit 2 and C in bit 0.
- R3: Zero-page store ($85) takes 3 bus cycles and ends in a write of A. Zero-page exclusive-OR ($45) takes 3 bus cycles and XORs the byte into A, updating N and Z.
- R4: Branch-if-not-equal ($D0) and the unconditional branch ($80) add a sign-extended 8-bit offset to the address of the next instruction. They take 2 bus cycles when not taken and 3 when taken. $80 exists only in personalities 1, 2 and 3.
- R5: In personality 0 (NMOS), $47 zp takes 5 cycles in this order: opcode read, operand read, data read, a write of the unmodified byte, then a write of the byte shifted right by one. The shifted byte is XORed into A, N and Z follow A, and C takes the bit shifted out.
- R6: In personality 1, every opcode whose two low bits are 11 (this includes $47 and $83) is a one-byte, one-cycle no-operation.
- R7: In personality 2, $47 zp takes 5 cycles in this order: opcode read, operand read, data read, a repeated read of the same address, then a write of the byte with bit 4 cleared. A and the flags are unchanged.
- R8: In personality 3, $47 dp takes 6 cycles. It reads the pointer's low, high and bank bytes from dp, dp+1 and dp+2, then reads the data at {bank,high,low} and XORs it into A, updating N and Z.
- R9: Address bits 23:16 are zero on every bus cycle except the long data read of R8.
- R10: An opcode outside the personality's subset sets halt_o. halt_o stays set and no further bus cycles occur until reset.
- R11: Take a start state of A=$4E, $83=$1D, $84=$85=0 and $1D=$6B. Running $47 $83 and then $45 $83 leaves A as ASCII 'N', 'S', 'C' or '8' for personalities 0, 1, 2 and 3.
- R12: rd_o and wr_o are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| variant_i | input | 2 | Personality: 0 NMOS, 1 plain CMOS, 2 bit-op CMOS, 3 16-bit-capable |
| rdata_i | input | 8 | Read data for the current address |
| addr_o | output | 24 | Bus address |
| wdata_o | output | 8 | Write data |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 3 | {N,Z,C} |
| halt_o | output | 1 | Sticky halt on an unsupported opcode |

## Verification
The bench goes after the $47 bus sequence in every personality. A core that wrote the shifted byte without first writing back the original byte, or that skipped the repeated read before the bit clear, gives the wrong per-cycle trace. A core that wrapped or misordered the pointer bytes reads the wrong far address. Random operands and pointers with non-zero banks show whether the upper address lines leak outside the long read. Other directed programs cover:
- branch offsets in both directions, taken and not taken;
- $80 halting the NMOS personality;
- compare at equality and across the sign boundary;
- a one-cycle no-operation that is miscounted, which shifts every later cycle count.

// File: rtl/vsx_pkg.sv
package vsx_pkg;
  typedef enum logic [1:0] {VAR_NMOS, VAR_SC, VAR_C, VAR_WIDE} variant_e;

  typedef enum logic [3:0] {
    C_LDA, C_STA, C_EOR, C_CMP, C_BNE, C_BRA,
    C_SRE, C_RMB, C_EORL, C_NOP1, C_BAD
  } cls_e;

  typedef enum logic [3:0] {
    S_FETCH, S_OPND, S_RD, S_RMW, S_WR,
    S_PL, S_PH, S_PB, S_RDL, S_BR, S_HALT
  } state_e;

  typedef enum logic [1:0] {F_LD, F_EOR, F_CMP} alu_e;
endpackage

// File: rtl/vsx_decode.sv
module vsx_decode
  import vsx_pkg::*;
(
  input  logic [7:0] op_i,
  input  variant_e   var_i,
  output cls_e       cls_o
);
  always_comb begin
    cls_o = C_BAD;
    if (var_i == VAR_SC && op_i[1:0] == 2'b11) begin
      cls_o = C_NOP1;
    end else begin
      case (op_i)
        8'hA9: cls_o = C_LDA;
        8'h85: cls_o = C_STA;
        8'h45: cls_o = C_EOR;
        8'hC9: cls_o = C_CMP;
        8'hD0: cls_o = C_BNE;
        8'h80: cls_o = (var_i == VAR_NMOS) ? C_BAD : C_BRA;
        8'h47: begin
          case (var_i)
            VAR_NMOS: cls_o = C_SRE;
            VAR_C:    cls_o = C_RMB;
            VAR_WIDE: cls_o = C_EORL;
            default:  cls_o = C_BAD;
          endcase
        end
        default: cls_o = C_BAD;
      endcase
    end
  end
endmodule

// File: rtl/vsx_alu.sv
module vsx_alu
  import vsx_pkg::*;
(
  input  alu_e       fn_i,
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  output logic [7:0] res_o,
  output logic       n_o,
  output logic       z_o,
  output logic       c_o
);
  logic [8:0] diff;
  logic [7:0] fv;

  always_comb begin
    diff  = {1'b0, a_i} - {1'b0, b_i};
    c_o   = 1'b0;
    res_o = a_i;
    fv    = a_i;
    case (fn_i)
      F_LD:    begin res_o = b_i;       fv = b_i; end
      F_EOR:   begin res_o = a_i ^ b_i; fv = a_i ^ b_i; end
      F_CMP:   begin fv = diff[7:0];    c_o = ~diff[8]; end
      default: ;
    endcase
    n_o = fv[7];
    z_o = (fv == 8'h00);
  end
endmodule

// File: rtl/vsx_core.sv
module vsx_core
  import vsx_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter logic [15:0] RESET_PC = 16'h0200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        variant_i,
  input  logic [7:0]        rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [7:0]        acc_o,
  output logic [2:0]        flags_o,
  output logic              halt_o
);
  localparam int BANK_W = ADDR_W - 16;

  state_e            state;
  cls_e              cls_q, cls_d;
  logic [15:0]       pc;
  logic [7:0]        a, opnd, tmp, ptr_hi;
  logic [BANK_W-1:0] bank;
  logic              n_f, z_f, c_f;

  logic [15:0]       addr16;
  logic [BANK_W-1:0] addr_hi;
  alu_e              alu_fn;
  logic [7:0]        alu_b, alu_res;
  logic              alu_n, alu_z, alu_c;

  vsx_decode u_dec (.op_i(rdata_i), .var_i(variant_e'(variant_i)), .cls_o(cls_d));

  always_comb begin
    case (cls_q)
      C_LDA:   alu_fn = F_LD;
      C_CMP:   alu_fn = F_CMP;
      default: alu_fn = F_EOR;
    endcase
    alu_b = (state == S_WR) ? tmp : rdata_i;
  end

  vsx_alu u_alu (
    .fn_i(alu_fn), .a_i(a), .b_i(alu_b),
    .res_o(alu_res), .n_o(alu_n), .z_o(alu_z), .c_o(alu_c)
  );

  // bus side of the current cycle
  always_comb begin
    addr16  = pc;
    addr_hi = '0;
    rd_o    = 1'b0;
    wr_o    = 1'b0;
    wdata_o = 8'h00;
    case (state)
      S_FETCH, S_OPND, S_BR: rd_o = 1'b1;
      S_RD: begin rd_o = 1'b1; addr16 = {8'h00, opnd}; end
      S_RMW: begin
        addr16 = {8'h00, opnd};
        if (cls_q == C_SRE) begin wr_o = 1'b1; wdata_o = tmp; end  // unmodified write-back
        else rd_o = 1'b1;                                         // repeated read
      end
      S_WR: begin
        wr_o    = 1'b1;
        addr16  = {8'h00, opnd};
        wdata_o = (cls_q == C_STA) ? a : tmp;
      end
      S_PL: begin rd_o = 1'b1; addr16 = {8'h00, opnd}; end
      S_PH: begin rd_o = 1'b1; addr16 = {8'h00, opnd} + 16'd1; end
      S_PB: begin rd_o = 1'b1; addr16 = {8'h00, opnd} + 16'd2; end
      S_RDL: begin rd_o = 1'b1; addr16 = {ptr_hi, tmp}; addr_hi = bank; end
      default: ;
    endcase
    addr_o = {addr_hi, addr16};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= S_FETCH;
      cls_q  <= C_NOP1;
      pc     <= RESET_PC;
      a      <= 8'h00;
      opnd   <= 8'h00;
      tmp    <= 8'h00;
      ptr_hi <= 8'h00;
      bank   <= '0;
      n_f    <= 1'b0;
      z_f    <= 1'b0;
      c_f    <= 1'b0;
    end else begin
      case (state)
        S_FETCH: begin
          pc    <= pc + 16'd1;
          cls_q <= cls_d;
          case (cls_d)
            C_NOP1:  state <= S_FETCH;
            C_BAD:   state <= S_HALT;
            default: state <= S_OPND;
          endcase
        end
        S_OPND: begin
          pc   <= pc + 16'd1;
          opnd <= rdata_i;
          case (cls_q)
            C_LDA: begin a <= alu_res; n_f <= alu_n; z_f <= alu_z; state <= S_FETCH; end
            C_CMP: begin n_f <= alu_n; z_f <= alu_z; c_f <= alu_c; state <= S_FETCH; end
            C_STA: state <= S_WR;
            C_EOR, C_SRE, C_RMB: state <= S_RD;
            C_EORL: state <= S_PL;
            C_BNE: state <= z_f ? S_FETCH : S_BR;
            C_BRA: state <= S_BR;
            default: state <= S_HALT;
          endcase
        end
        S_BR: begin
          pc    <= pc + {{8{opnd[7]}}, opnd};
          state <= S_FETCH;
        end
        S_RD: begin
          if (cls_q == C_EOR) begin
            a <= alu_res; n_f <= alu_n; z_f <= alu_z;
            state <= S_FETCH;
          end else begin
            tmp   <= rdata_i;
            state <= S_RMW;
          end
        end
        S_RMW: begin
          if (cls_q == C_SRE) begin
            tmp <= {1'b0, tmp[7:1]};
            c_f <= tmp[0];
          end else begin
            tmp <= tmp & 8'hEF;
          end
          state <= S_WR;
        end
        S_WR: begin
          if (cls_q == C_SRE) begin
            a <= alu_res; n_f <= alu_n; z_f <= alu_z;
          end
          state <= S_FETCH;
        end
        S_PL: begin tmp <= rdata_i; state <= S_PH; end
        S_PH: begin ptr_hi <= rdata_i; state <= S_PB; end
        S_PB: begin bank <= BANK_W'(rdata_i); state <= S_RDL; end
        S_RDL: begin
          a <= alu_res; n_f <= alu_n; z_f <= alu_z;
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assign acc_o   = a;
  assign flags_o = {n_f, z_f, c_f};
  assign halt_o  = (state == S_HALT);
endmodule

// File: rtl/vsx_core_chk.sv
module vsx_core_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        variant_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              rd_o,
  input logic              wr_o,
  input logic [7:0]        acc_o,
  input logic              halt_o
);
  a_r12_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (variant_i != 2'd3) |-> (addr_o[ADDR_W-1:16] == '0));

  a_r10_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  a_r10_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (!rd_o && !wr_o));

  a_r7_write_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (variant_i == 2'd2 && wr_o) |=> $stable(acc_o));
endmodule

bind vsx_core vsx_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .variant_i(variant_i), .addr_o(addr_o),
  .rd_o(rd_o), .wr_o(wr_o), .acc_o(acc_o), .halt_o(halt_o)
);

// File: tb/vsx_core_test.sv
module vsx_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  variant = 2'd0;
  logic [7:0]  rdata, wdata;
  logic [23:0] addr;
  logic        rd, wr, halt;
  logic [7:0]  acc;
  logic [2:0]  flags;

  logic [7:0]  mem [0:4095];
  logic [33:0] tr [0:63];
  int          tr_n = 0, bus_cnt = 0, upper_bad = 0, both_bad = 0;
  int          n_chk = 0, n_fail = 0, cyc_total = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsx_core uut (
    .clk_i(clk), .rst_ni(rst_n), .variant_i(variant), .rdata_i(rdata),
    .addr_o(addr), .wdata_o(wdata), .rd_o(rd), .wr_o(wr),
    .acc_o(acc), .flags_o(flags), .halt_o(halt)
  );

  function automatic logic [7:0] far_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  function automatic logic [33:0] ent(input logic r, input logic w,
                                      input logic [23:0] a, input logic [7:0] d);
    return {r, w, a, w ? d : 8'h00};
  endfunction

  assign rdata = (addr[23:16] != 8'h00) ? far_byte(addr) : mem[addr[11:0]];

  // bus monitor and memory writes, mid-cycle
  always @(negedge clk) begin
    if (rst_n && (rd || wr)) begin
      if (tr_n < 64) tr[tr_n] = ent(rd, wr, addr, wdata);
      tr_n++;
      bus_cnt++;
      if (variant != 2'd3 && addr[23:16] != 8'h00) upper_bad++;
      if (rd && wr) both_bad++;
      if (wr && addr[23:16] == 8'h00) mem[addr[11:0]] = wdata;
    end
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc_total, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask

  task automatic run(input logic [1:0] v, output int cyc);
    int k;
    variant = v;
    rst_n   = 1'b0;
    repeat (2) @(negedge clk);
    tr_n = 0; bus_cnt = 0;
    @(posedge clk);
    rst_n <= 1'b1;
    k = 0;
    @(negedge clk);
    while (!halt && k < 400) begin
      @(negedge clk);
      k++;
    end
    repeat (3) @(negedge clk);
    cyc = bus_cnt;
  endtask

  task automatic load_id();
    logic [7:0] p [20] = '{8'hA9,8'h00, 8'h85,8'h84, 8'h85,8'h85, 8'hA9,8'h1D,
                           8'h85,8'h83, 8'hA9,8'h6B, 8'h85,8'h1D, 8'hA9,8'h4E,
                           8'h47,8'h83, 8'h45,8'h83};
    clear_mem();
    for (int i = 0; i < 20; i++) mem[12'h200 + i] = p[i];
    mem[12'h214] = 8'h02;
  endtask

  initial begin
    int cyc;
    logic [7:0] exp_acc [4]  = '{8'h4E, 8'h53, 8'h43, 8'h38};
    logic [7:0] exp_m83 [4]  = '{8'h0E, 8'h1D, 8'h0D, 8'h1D};
    int         exp_cyc [4]  = '{29, 26, 29, 30};

    void'($urandom(32'd7121));

    // R1: reset state
    clear_mem();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset bus", {9'd0, rd, wr, addr}, {9'd0, 1'b1, 1'b0, 24'h000200});
    chk("R1 reset regs", {22'd0, acc, flags, halt}, 34'd0);

    // R11 with per-personality cycle totals and $47 bus traces
    for (int v = 0; v < 4; v++) begin
      load_id();
      run(v[1:0], cyc);
      chk("R11 id char", {26'd0, acc}, {26'd0, exp_acc[v]});
      chk("R11 id cycles", 34'(cyc), 34'(exp_cyc[v]));
      chk("R11 id mem83", {26'd0, mem[12'h083]}, {26'd0, exp_m83[v]});
      chk("R3 store fetch", tr[20], ent(1'b1, 1'b0, 24'h000210, 8'h00));
      case (v)
        0: begin
          chk("R5 read",    tr[22], ent(1'b1, 1'b0, 24'h000083, 8'h00));
          chk("R5 wr orig", tr[23], ent(1'b0, 1'b1, 24'h000083, 8'h1D));
          chk("R5 wr shft", tr[24], ent(1'b0, 1'b1, 24'h000083, 8'h0E));
          chk("R5 next",    tr[25], ent(1'b1, 1'b0, 24'h000212, 8'h00));
        end
        1: begin
          chk("R6 nop83",   tr[21], ent(1'b1, 1'b0, 24'h000211, 8'h00));
          chk("R6 next",    tr[22], ent(1'b1, 1'b0, 24'h000212, 8'h00));
        end
        2: begin
          chk("R7 read",    tr[22], ent(1'b1, 1'b0, 24'h000083, 8'h00));
          chk("R7 reread",  tr[23], ent(1'b1, 1'b0, 24'h000083, 8'h00));
          chk("R7 write",   tr[24], ent(1'b0, 1'b1, 24'h000083, 8'h0D));
          chk("R7 next",    tr[25], ent(1'b1, 1'b0, 24'h000212, 8'h00));
        end
        default: begin
          chk("R8 ptr lo",  tr[22], ent(1'b1, 1'b0, 24'h000083, 8'h00));
          chk("R8 ptr hi",  tr[23], ent(1'b1, 1'b0, 24'h000084, 8'h00));
          chk("R8 ptr bank",tr[24], ent(1'b1, 1'b0, 24'h000085, 8'h00));
          chk("R8 data",    tr[25], ent(1'b1, 1'b0, 24'h00001D, 8'h00));
          chk("R8 next",    tr[26], ent(1'b1, 1'b0, 24'h000212, 8'h00));
        end
      endcase
    end

    // R5 R6 R7 R8 random operands and pointers
    for (int it = 0; it < 24; it++) begin
      logic [1:0]  v;
      logic [7:0]  a0, zp, m, hi, bk, d, ea;
      logic [2:0]  ef;
      logic [7:0]  em;
      int          ec;
      v  = 2'($urandom_range(0, 3));
      a0 = 8'($urandom);
      zp = {1'b0, 5'($urandom), 2'b11};
      m  = 8'($urandom);
      hi = 8'($urandom);
      bk = 8'($urandom_range(1, 255));
      clear_mem();
      mem[12'h200] = 8'hA9; mem[12'h201] = a0;
      mem[12'h202] = 8'h47; mem[12'h203] = zp; mem[12'h204] = 8'h02;
      mem[{4'h0, zp}] = m; mem[{4'h0, zp} + 12'd1] = hi; mem[{4'h0, zp} + 12'd2] = bk;
      ea = a0; em = m; ef = {a0[7], a0 == 8'h00, 1'b0}; ec = 8;
      d  = far_byte({bk, hi, m});
      case (v)
        2'd0: begin ea = a0 ^ {1'b0, m[7:1]}; em = {1'b0, m[7:1]}; ef = {ea[7], ea == 8'h00, m[0]}; end
        2'd1: ec = 5;
        2'd2: em = m & 8'hEF;
        default: begin ea = a0 ^ d; ef = {ea[7], ea == 8'h00, 1'b0}; ec = 9; end
      endcase
      run(v, cyc);
      chk("R5-8 rand acc",    {26'd0, acc}, {26'd0, ea});
      chk("R5-8 rand flags",  {31'd0, flags}, {31'd0, ef});
      chk("R5-8 rand mem",    {26'd0, mem[{4'h0, zp}]}, {26'd0, em});
      chk("R5-8 rand cycles", 34'(cyc), 34'(ec));
      if (v == 2'd3) chk("R8 R9 far addr", tr[7], ent(1'b1, 1'b0, {bk, hi, m}, 8'h00));
    end

    // R4 branches, R10 halt on $80 in NMOS
    for (int v = 0; v < 4; v++) begin
      logic [7:0] p [16] = '{8'hA9,8'h00, 8'hD0,8'h02, 8'hC9,8'h01, 8'hD0,8'h02,
                             8'hA9,8'h11, 8'h80,8'h04, 8'hA9,8'h44, 8'h02,8'h00};
      clear_mem();
      for (int i = 0; i < 16; i++) mem[12'h200 + i] = p[i];
      mem[12'h210] = 8'h80; mem[12'h211] = 8'hFA;
      run(v[1:0], cyc);
      if (v == 0) begin
        chk("R4 R10 nmos bra acc",    {26'd0, acc}, 34'h00);
        chk("R4 R10 nmos bra cycles", 34'(cyc), 34'd10);
        chk("R10 halt held",          {33'd0, halt}, 34'd1);
      end else begin
        chk("R4 branch acc",    {26'd0, acc}, 34'h44);
        chk("R4 branch cycles", 34'(cyc), 34'd18);
        chk("R4 branch flags",  {31'd0, flags}, 34'd0);
      end
    end

    // R2 compare: equality and across sign
    clear_mem();
    mem[12'h200] = 8'hA9; mem[12'h201] = 8'h80; mem[12'h202] = 8'hC9; mem[12'h203] = 8'h80;
    mem[12'h204] = 8'h02;
    run(2'd2, cyc);
    chk("R2 cmp equal flags", {31'd0, flags}, 34'b011);
    chk("R2 cmp cycles",      34'(cyc), 34'd5);
    mem[12'h201] = 8'h05;
    run(2'd0, cyc);
    chk("R2 cmp less flags", {31'd0, flags}, 34'b100);
    chk("R2 cmp keeps acc",  {26'd0, acc}, 34'h05);

    // R6 vs R10: $83 opcode
    clear_mem();
    mem[12'h200] = 8'h83; mem[12'h201] = 8'h02;
    run(2'd1, cyc);
    chk("R6 nop83 cycles", 34'(cyc), 34'd2);
    run(2'd0, cyc);
    chk("R10 bad op cycles", 34'(cyc), 34'd1);
    chk("R10 bad op halt",   {33'd0, halt}, 34'd1);

    chk("R9 upper zero", 34'(upper_bad), 34'd0);
    chk("R12 rd wr excl", 34'(both_bad), 34'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule